// File: doc/BRIEF.md
# Bidirectional Universal Bus Transceiver

This block couples two 18-bit ports, A and B, through two independent storage lanes, one per direction. Each lane owns a latch enable, a strobe and an output enable. With its latch enable high a lane is transparent, and its outgoing data follows the incoming port at once. With the latch enable low the lane holds its stored word. While the latch enable is low, the lane loads a new word only when the strobe goes from high to low.

All control and data inputs are sampled by a system clock `clk`. A strobe falling edge is detected between two successive samples. Each lane keeps the strobe level it saw last, together with the latch enable, in a four-state machine. The states are:
- `ST_PASS_HI` and `ST_PASS_LO`: transparent, with the strobe last seen high or low.
- `ST_HOLD_HI` and `ST_HOLD_LO`: holding, with the strobe last seen high or low.

On every clock edge the next state is taken directly from the sampled latch enable and strobe, so any state can reach any other state. A capture fires when the latch enable is low, the present state is `ST_PASS_HI` or `ST_HOLD_HI`, and the strobe is now low. Reset enters `ST_HOLD_LO`, so a strobe that is low straight after reset captures nothing.

Ports are modelled as separate input, output and drive-enable signals. A wrapper one level up can merge them onto inout nets. The A-to-B drive enable is active high and the B-to-A drive enable is active low. Output enables gate only the drive flags; storage keeps running while a port is released.

Top module: `ubt_xcvr`

## Requirements
- R1: The data width is 18 bits by default. While `rst_n` is low, both stored words are cleared, so with both latch enables low `b_o` and `a_o` read 0.
- R2: While `ab_le` is 1, `b_o` equals `a_i` in the same cycle with no clock edge needed, and it tracks every change of `a_i`.
- R3: While `ab_le` is 0 and `ab_stb` does not fall, `b_o` keeps its value whatever `a_i` does.
- R4: At a clock edge where `ab_le` is 0, the previous sample of `ab_stb` was 1 and the present sample is 0, the word on `a_i` is stored and appears on `b_o` after that edge.
- R5: When `ab_le` drops to 0, `b_o` shows the `a_i` value sampled at the last clock edge at which `ab_le` was 1.
- R6: `b_oe_o` equals `ab_oe` (active high). `b_o` keeps updating while `ab_oe` is 0.
- R7: `a_oe_o` is the inverse of `ba_oe_n` (active low).
- R8: The B-to-A lane follows R2 to R5 with `ba_le`, `ba_stb`, `b_i` and `a_o`.
- R9: A rising edge of a strobe while its latch enable is 0 stores nothing.
- R10: Both lanes operate at the same time with no effect on each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_oe | input | 1 | A-to-B drive enable, active high |
| ab_le | input | 1 | A-to-B latch enable |
| ab_stb | input | 1 | A-to-B strobe, falling edge captures |
| a_i | input | 18 | Data arriving from port A |
| b_o | output | 18 | Data toward port B |
| b_oe_o | output | 1 | Drive flag for port B |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_stb | input | 1 | B-to-A strobe, falling edge captures |
| b_i | input | 18 | Data arriving from port B |
| a_o | output | 18 | Data toward port A |
| a_oe_o | output | 1 | Drive flag for port A |

## Verification
The assertions assume that every control input and data word is synchronous to `clk` and stable around each rising edge. A strobe edge is therefore only ever seen as a change between two samples. They also ignore the first cycle after reset, because the strobe level from before reset is not known to the lane. The stimulus changes inputs only just after a rising edge and holds each strobe level for at least one full cycle. It also leaves a settling cycle after reset before any strobe falls.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int unsigned XCVR_W = 18;

    // {latch enable, last strobe level}
    typedef enum logic [1:0] {
        ST_HOLD_LO = 2'b00,
        ST_HOLD_HI = 2'b01,
        ST_PASS_LO = 2'b10,
        ST_PASS_HI = 2'b11
    } lane_state_t;

endpackage

// File: rtl/ubt_mode_fsm.sv
module ubt_mode_fsm
    import ubt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le,
    input  logic stb,
    output logic load
);

    lane_state_t state_q;
    lane_state_t state_d;
    logic        stb_was_hi;

    always_comb begin
        unique case ({le, stb})
            2'b00:   state_d = ST_HOLD_LO;
            2'b01:   state_d = ST_HOLD_HI;
            2'b10:   state_d = ST_PASS_LO;
            default: state_d = ST_PASS_HI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_HOLD_HI, ST_PASS_HI: stb_was_hi = 1'b1;
            default:                stb_was_hi = 1'b0;
        endcase
        // track while transparent, capture on strobe fall while closed
        load = le | (stb_was_hi & ~stb);
    end

endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= din;
    end

    assign dout = le ? din : word_q;

endmodule

// File: rtl/ubt_lane.sv
module ubt_lane #(
    parameter int unsigned W          = 18,
    parameter bit          OE_ACT_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe,
    input  logic         le,
    input  logic         stb,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);

    logic load;

    ubt_mode_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le),
        .stb   (stb),
        .load  (load)
    );

    ubt_store #(.W(W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le),
        .load  (load),
        .din   (din),
        .dout  (dout)
    );

    generate
        if (OE_ACT_LOW) begin : g_oe_low
            assign drive = ~oe;
        end else begin : g_oe_high
            assign drive = oe;
        end
    endgenerate

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ab_oe,
    input  logic         ab_le,
    input  logic         ab_stb,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] b_o,
    output logic         b_oe_o,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_stb,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_o,
    output logic         a_oe_o
);

    ubt_lane #(.W(W), .OE_ACT_LOW(1'b0)) u_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .oe    (ab_oe),
        .le    (ab_le),
        .stb   (ab_stb),
        .din   (a_i),
        .dout  (b_o),
        .drive (b_oe_o)
    );

    ubt_lane #(.W(W), .OE_ACT_LOW(1'b1)) u_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .oe    (ba_oe_n),
        .le    (ba_le),
        .stb   (ba_stb),
        .din   (b_i),
        .dout  (a_o),
        .drive (a_oe_o)
    );

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ab_oe,
    input logic         ab_le,
    input logic         ab_stb,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_o,
    input logic         b_oe_o,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_stb,
    input logic [W-1:0] b_i,
    input logic [W-1:0] a_o,
    input logic         a_oe_o
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r2_ab_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |-> (b_o == a_i));

    a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ab_le && !($past(ab_stb) && !ab_stb)) |=> (ab_le || $stable(b_o)));

    a_r4_ab_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ab_le && $past(ab_stb) && !ab_stb) |=> (ab_le || b_o == $past(a_i)));

    a_r5_ab_close: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(ab_le) && !($past(ab_stb) && !ab_stb)) |-> (b_o == $past(a_i)));

    a_r6_b_drive: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe_o == ab_oe);

    a_r7_a_drive: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe_o != ba_oe_n);

    a_r8_ba_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |-> (a_o == b_i));

    a_r8_ba_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ba_le && $past(ba_stb) && !ba_stb) |=> (ba_le || a_o == $past(b_i)));

endmodule

bind ubt_xcvr ubt_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/tb_ubt_xcvr.sv
module tb_ubt_xcvr;

    localparam int unsigned W = 18;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic ab_oe, ab_le, ab_stb, ba_oe_n, ba_le, ba_stb;
    logic [W-1:0] a_i, b_i, b_o, a_o;
    logic b_oe_o, a_oe_o;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ubt_xcvr #(.W(W)) dut (.*);

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ab_oe = 0; ab_le = 0; ab_stb = 0; a_i = '1;
        ba_oe_n = 1; ba_le = 0; ba_stb = 0; b_i = '1;
        repeat (3) tick();
        chk("R1 b_o after reset", b_o, '0);
        chk("R1 a_o after reset", a_o, '0);
        chk("R6 b drive off", {17'd0, b_oe_o}, '0);
        chk("R7 a drive off", {17'd0, a_oe_o}, '0);
        rst_n = 1'b1;
        tick();
        chk("R1 b_o held after release", b_o, '0);
    endtask

    task automatic t_transparent();
        ab_le = 1; a_i = 18'h2A5A5; #1;
        chk("R2 follows", b_o, 18'h2A5A5);
        a_i = 18'h15A5A; #1;
        chk("R2 follows without clock", b_o, 18'h15A5A);
        tick();
        ab_le = 0; a_i = 18'h00F0F; #1;
        chk("R5 keeps last open value", b_o, 18'h15A5A);
    endtask

    task automatic t_hold();
        a_i = 18'h3FFFF; tick();
        a_i = 18'h00001; tick();
        chk("R3 hold strobe low", b_o, 18'h15A5A);
        ab_stb = 1; tick();
        chk("R9 rising strobe no capture", b_o, 18'h15A5A);
        a_i = 18'h12345; tick(); tick();
        chk("R3 hold strobe high", b_o, 18'h15A5A);
    endtask

    task automatic t_capture();
        a_i = 18'h0ABCD; ab_stb = 0; tick();
        chk("R4 capture on strobe fall", b_o, 18'h0ABCD);
        a_i = 18'h33333; tick();
        chk("R3 hold after capture", b_o, 18'h0ABCD);
    endtask

    task automatic t_le_toggle_stb_high();
        ab_stb = 1; tick();
        ab_le = 1; a_i = 18'h11111; tick();
        ab_le = 0; a_i = 18'h22222; #1;
        chk("R5 close with strobe high", b_o, 18'h11111);
        tick();
        chk("R3 closed strobe high", b_o, 18'h11111);
        ab_stb = 0; tick();
        chk("R4 later fall captures", b_o, 18'h22222);
    endtask

    task automatic t_oe();
        ab_oe = 0; ab_le = 1; a_i = 18'h0C0C0; #1;
        chk("R6 data moves while released", b_o, 18'h0C0C0);
        chk("R6 drive low", {17'd0, b_oe_o}, '0);
        ab_oe = 1; #1;
        chk("R6 drive high", {17'd0, b_oe_o}, 18'd1);
        tick(); ab_le = 0; ab_oe = 0; a_i = '0; tick();
        ab_oe = 1; #1;
        chk("R6 storage kept while released", b_o, 18'h0C0C0);
    endtask

    task automatic t_ba();
        ba_oe_n = 0; #1;
        chk("R7 a drive on", {17'd0, a_oe_o}, 18'd1);
        ba_le = 1; b_i = 18'h1F00F; #1;
        chk("R8 transparent", a_o, 18'h1F00F);
        tick(); ba_le = 0; b_i = 18'h00077; #1;
        chk("R8 close keeps value", a_o, 18'h1F00F);
        ba_stb = 1; tick();
        chk("R8 rise no capture", a_o, 18'h1F00F);
        ba_stb = 0; tick();
        chk("R8 fall captures", a_o, 18'h00077);
        ba_oe_n = 1; #1;
        chk("R7 a drive off again", {17'd0, a_oe_o}, '0);
    endtask

    task automatic t_both();
        ab_oe = 1; ba_oe_n = 0;
        ab_stb = 1; ba_stb = 1; tick();
        a_i = 18'h2AAAA; b_i = 18'h15555; ab_stb = 0; ba_stb = 0; tick();
        chk("R10 A-to-B capture", b_o, 18'h2AAAA);
        chk("R10 B-to-A capture", a_o, 18'h15555);
        ab_le = 1; a_i = 18'h01234; #1;
        chk("R10 B-to-A undisturbed", a_o, 18'h15555);
        chk("R10 A-to-B transparent", b_o, 18'h01234);
        ab_le = 0;
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_hold();
        t_capture();
        t_le_toggle_stb_high();
        t_oe();
        t_ba();
        t_both();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule